// File: doc/BRIEF.md
# Nonvolatile SRAM Mode Controller

This block is a clocked model of a byte-wide static memory paired with a second, nonvolatile array of the same size. In normal operation it acts as a plain SRAM. Four active-low controls are decoded into read and write cycles: chip enable, output enable, write enable and a hardware-store line. Read data leaves on a data bus with a separate drive-enable. A write is committed on the clock edge where the write condition ends.

The block also has a transfer mode. A recall copies the nonvolatile array into the SRAM. A store copies the SRAM into the nonvolatile array. The store is requested by an external trigger. The supply state arrives as two digital flags: supply below the reset level, and supply above the switch level. A low-supply event latches a recall request, and so does reset, which stands in for power-up. The recall starts by itself once the supply is back above the switch level.

Every transfer runs for a fixed, parameterised number of clock cycles and raises the busy output for that whole time. While busy is high, SRAM reads and writes are locked out. A write that is still in progress when a recall finishes raises a sticky corruption flag.

Top module: `nvsram_ctrl`

## Requirements
- R1: When e_ni=0, g_ni=0, w_ni=1, hsb_ni=1 and busy_o=0 at a clock edge, data_oe_o is 1 and data_o holds the byte stored at addr_i after that edge.
- R2: While the read condition holds, data_o tracks every change of addr_i one cycle later, with no control toggling.
- R3: data_oe_o is 0 one cycle after any edge where e_ni=1, g_ni=1, w_ni=0 or hsb_ni=0. This includes a write with g_ni held low.
- R4: A write is active while e_ni=0, w_ni=0 and hsb_ni=1. On the first edge where it is no longer active, data_i is stored at addr_i as sampled on that edge.
- R5: Holding e_ni=0 and w_ni=0 with hsb_ni=0 leaves the SRAM unchanged.
- R6: Reset latches a recall request without starting it. The recall begins on the first edge with supply_ok_i=1 and supply_low_i=0, and busy_o then stays high for exactly RECALL_CYC cycles.
- R7: An edge with supply_low_i=1 latches a recall request. After recovery, the recall makes every SRAM byte equal to the nonvolatile byte at the same address.
- R8: A store_req_i pulse while idle, with no recall pending and supply_low_i=0, copies the SRAM into the nonvolatile array and holds busy_o high for STORE_CYC cycles. At any other time the pulse is ignored.
- R9: While busy_o=1, a read leaves data_oe_o at 0, and a write that ends during the busy period stores nothing.
- R10: If a write is active on the final edge of a recall, corrupt_o goes to 1 and stays there until the next recall starts. The write still commits when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| e_ni | input | 1 | Chip enable, active low |
| g_ni | input | 1 | Output enable, active low |
| w_ni | input | 1 | Write enable, active low |
| hsb_ni | input | 1 | Hardware-store line, active low; blocks access when low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Write data |
| supply_low_i | input | 1 | Supply below reset level |
| supply_ok_i | input | 1 | Supply above switch level |
| store_req_i | input | 1 | Store trigger from external logic |
| data_o | output | DATA_W | Read data |
| data_oe_o | output | 1 | Drive enable for data_o |
| busy_o | output | 1 | Recall or store in progress |
| corrupt_o | output | 1 | Write overlapped the end of a recall |

## Verification
Read data and its enable appear one clock after the edge that samples the controls and address. The bench drives on the falling edge and checks on the next falling edge. A write becomes visible only after the second rising edge of the write task, where the write ends, so the read-back check is always issued after that. Busy becomes visible on the falling edge after the start edge. The bench then counts busy samples on falling edges and compares the count to the cycle parameter. The corruption flag is checked on the falling edge after busy drops, and its clearing is checked on the first busy sample of the next recall.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_RECALL = 2'd1,
    XF_STORE  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/nvsram_access_dec.sv
module nvsram_access_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic e_ni,
  input  logic g_ni,
  input  logic w_ni,
  input  logic hsb_ni,
  input  logic busy_i,
  output logic rd_oe_o,
  output logic wr_act_o,
  output logic wr_commit_o
);
  logic rd_en;
  logic wr_act_q;
  logic rd_oe_q;

  assign rd_en    = !e_ni && !g_ni && w_ni && hsb_ni && !busy_i;
  assign wr_act_o = !e_ni && !w_ni && hsb_ni;
  // commit on the edge where the write condition falls away
  assign wr_commit_o = wr_act_q && !wr_act_o && !busy_i;
  assign rd_oe_o     = rd_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rd_oe_q  <= 1'b0;
    end else begin
      wr_act_q <= wr_act_o && !busy_i;
      rd_oe_q  <= rd_en;
    end
  end

  AST_OE_OFF_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !rd_oe_q); // R9
  AST_OE_NEEDS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_q |-> $past(w_ni && hsb_ni && !e_ni && !g_ni)); // R3
endmodule

// File: rtl/nvsram_xfer_seq.sv
module nvsram_xfer_seq
  import nvsram_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int RECALL_CYC = 300,
  parameter int STORE_CYC  = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_low_i,
  input  logic              supply_ok_i,
  input  logic              store_req_i,
  input  logic              wr_act_i,
  output logic              busy_o,
  output logic              xfer_en_o,
  output xfer_state_e       xfer_mode_o,
  output logic [ADDR_W-1:0] xfer_idx_o,
  output logic              corrupt_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int RECALL_LEN = (RECALL_CYC > DEPTH) ? RECALL_CYC : DEPTH;
  localparam int STORE_LEN  = (STORE_CYC > DEPTH) ? STORE_CYC : DEPTH;
  localparam int MAX_LEN    = (RECALL_LEN > STORE_LEN) ? RECALL_LEN : STORE_LEN;
  localparam int CNT_W      = $clog2(MAX_LEN + 1);

  xfer_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             corrupt_q;
  logic             last;
  logic             start_rec;
  logic             start_sto;

  assign last = ((state_q == XF_RECALL) && (cnt_q == CNT_W'(RECALL_LEN - 1))) ||
                ((state_q == XF_STORE)  && (cnt_q == CNT_W'(STORE_LEN - 1)));
  assign start_rec = (state_q == XF_IDLE) && req_q && supply_ok_i && !supply_low_i;
  assign start_sto = (state_q == XF_IDLE) && !req_q && !supply_low_i && store_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b1;  // power-up recall request
    end else if (supply_low_i) begin
      req_q <= 1'b1;
    end else if (start_rec) begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        XF_IDLE: begin
          cnt_q <= '0;
          if (start_rec)      state_q <= XF_RECALL;
          else if (start_sto) state_q <= XF_STORE;
        end
        default: begin
          if (last) begin
            state_q <= XF_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corrupt_q <= 1'b0;
    end else if (start_rec) begin
      corrupt_q <= 1'b0;
    end else if ((state_q == XF_RECALL) && last && wr_act_i) begin
      corrupt_q <= 1'b1;
    end
  end

  assign busy_o      = (state_q != XF_IDLE);
  assign xfer_en_o   = busy_o && (cnt_q < CNT_W'(DEPTH));
  assign xfer_mode_o = state_q;
  assign xfer_idx_o  = cnt_q[ADDR_W-1:0];
  assign corrupt_o   = corrupt_q;

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last) |=> (state_q == $past(state_q))); // R6
  AST_LAST_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> !busy_o); // R8
  AST_NO_STORE_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == XF_IDLE) && supply_low_i) |=> (state_q == XF_IDLE)); // R8
  AST_CORRUPT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(corrupt_q) |-> $past(state_q == XF_RECALL)); // R10
endmodule

// File: rtl/nvsram_arrays.sv
module nvsram_arrays
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              xfer_en_i,
  input  xfer_state_e       xfer_mode_i,
  input  logic [ADDR_W-1:0] xfer_idx_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sram_q [DEPTH];
  logic [DATA_W-1:0] nv_q   [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    rd_q <= sram_q[rd_addr_i];
    if (xfer_en_i && (xfer_mode_i == XF_RECALL)) begin
      sram_q[xfer_idx_i] <= nv_q[xfer_idx_i];
    end else if (wr_en_i) begin
      sram_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (xfer_en_i && (xfer_mode_i == XF_STORE)) begin
      nv_q[xfer_idx_i] <= sram_q[xfer_idx_i];
    end
  end

  assign rd_data_o = rd_q;

  AST_NO_WRITE_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !xfer_en_i); // R9
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int RECALL_CYC = 300,
  parameter int STORE_CYC  = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e_ni,
  input  logic              g_ni,
  input  logic              w_ni,
  input  logic              hsb_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              supply_low_i,
  input  logic              supply_ok_i,
  input  logic              store_req_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic              corrupt_o
);
  logic              busy;
  logic              wr_act;
  logic              wr_commit;
  logic              xfer_en;
  xfer_state_e       xfer_mode;
  logic [ADDR_W-1:0] xfer_idx;

  nvsram_access_dec u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .e_ni        (e_ni),
    .g_ni        (g_ni),
    .w_ni        (w_ni),
    .hsb_ni      (hsb_ni),
    .busy_i      (busy),
    .rd_oe_o     (data_oe_o),
    .wr_act_o    (wr_act),
    .wr_commit_o (wr_commit)
  );

  nvsram_xfer_seq #(
    .ADDR_W     (ADDR_W),
    .RECALL_CYC (RECALL_CYC),
    .STORE_CYC  (STORE_CYC)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .supply_low_i (supply_low_i),
    .supply_ok_i  (supply_ok_i),
    .store_req_i  (store_req_i),
    .wr_act_i     (wr_act),
    .busy_o       (busy),
    .xfer_en_o    (xfer_en),
    .xfer_mode_o  (xfer_mode),
    .xfer_idx_o   (xfer_idx),
    .corrupt_o    (corrupt_o)
  );

  nvsram_arrays #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_addr_i   (addr_i),
    .rd_data_o   (data_o),
    .wr_en_i     (wr_commit),
    .wr_addr_i   (addr_i),
    .wr_data_i   (data_i),
    .xfer_en_i   (xfer_en),
    .xfer_mode_i (xfer_mode),
    .xfer_idx_i  (xfer_idx)
  );

  assign busy_o = busy;

  AST_OE_NOT_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e_ni && !w_ni) |=> !data_oe_o); // R3
endmodule

// File: tb/nvsram_ctrl_tb.sv
`timescale 1ns/100ps
module nvsram_ctrl_tb_top;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int DEP = 1 << AW;
  localparam int RCL = 300;
  localparam int STO = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic e_n = 1'b1, g_n = 1'b1, w_n = 1'b1, hsb_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic sup_low = 1'b0, sup_ok = 1'b0, sto_req = 1'b0;
  logic [DW-1:0] dout;
  logic oe, busy, corrupt;

  logic [DW-1:0] sram_m [DEP];
  logic [DW-1:0] nv_m   [DEP];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvsram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RECALL_CYC(RCL), .STORE_CYC(STO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .e_ni(e_n), .g_ni(g_n), .w_ni(w_n), .hsb_ni(hsb_n),
    .addr_i(addr), .data_i(din), .supply_low_i(sup_low), .supply_ok_i(sup_ok),
    .store_req_i(sto_req), .data_o(dout), .data_oe_o(oe), .busy_o(busy), .corrupt_o(corrupt)
  );

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    return sram_m[a];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    e_n = 1'b1; g_n = 1'b1; w_n = 1'b1; hsb_n = 1'b1;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    e_n = 1'b0; g_n = 1'b0; w_n = 1'b1; hsb_n = 1'b1; addr = a;
    @(negedge clk);
    chk(oe === 1'b1, req, int'(oe), 1);
    chk(dout === exp_rd(a), req, int'(dout), int'(exp_rd(a)));
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit upd);
    @(negedge clk);
    e_n = 1'b0; g_n = 1'b1; w_n = 1'b0; hsb_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    w_n = 1'b1;
    @(negedge clk);
    e_n = 1'b1;
    if (upd) sram_m[a] = d;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic supply_dip();
    @(negedge clk);
    sup_low = 1'b1; sup_ok = 1'b0;
    @(negedge clk);
    sup_low = 1'b0; sup_ok = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state, request latched but held while supply not ok
    chk(busy === 1'b0, "R6 reset busy", int'(busy), 0);
    chk(oe === 1'b0, "R6 reset oe", int'(oe), 0);
    chk(corrupt === 1'b0, "R6 reset corrupt", int'(corrupt), 0);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R6 waits for supply", int'(busy), 0);
    sup_ok = 1'b1;
    @(negedge clk);
    count_busy(n);
    chk(n == RCL, "R6 power-up recall length", n, RCL);

    for (int a = 0; a < DEP; a++) do_write(AW'(a), DW'($urandom), 1'b1);
    for (int a = 0; a < 8; a++) do_read(AW'($urandom), "R4 fill readback");

    // R8: store
    @(negedge clk);
    sto_req = 1'b1;
    @(negedge clk);
    sto_req = 1'b0;
    count_busy(n);
    chk(n == STO, "R8 store length", n, STO);
    for (int a = 0; a < DEP; a++) nv_m[a] = sram_m[a];

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [AW-1:0] a;
      op = $urandom % 3;
      a = AW'($urandom);
      if (op == 0) begin
        do_read(a, "R1 random read");
      end else if (op == 1) begin
        do_write(a, DW'($urandom), 1'b1);
      end else begin
        int which;
        which = $urandom % 3;
        @(negedge clk);
        e_n = (which == 0); g_n = (which == 1); w_n = 1'b1; hsb_n = (which != 2); addr = a;
        @(negedge clk);
        chk(oe === 1'b0, "R3 read disabled", int'(oe), 0);
      end
    end

    // R2: address follow with controls held
    @(negedge clk);
    e_n = 1'b0; g_n = 1'b0; w_n = 1'b1; hsb_n = 1'b1; addr = 8'd3;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(oe === 1'b1 && dout === exp_rd(addr), "R2 follow", int'(dout), int'(exp_rd(addr)));
      addr = AW'(addr + 8'd37);
    end

    // R3: write with G low keeps output off
    @(negedge clk);
    e_n = 1'b0; g_n = 1'b0; w_n = 1'b0; hsb_n = 1'b1; addr = 8'd10; din = 8'h5A;
    @(negedge clk);
    chk(oe === 1'b0, "R3 write with g low", int'(oe), 0);
    w_n = 1'b1; g_n = 1'b1;
    @(negedge clk);
    idle();
    sram_m[10] = 8'h5A;
    do_read(8'd10, "R4 write commit");

    // R5: hsb low blocks write
    @(negedge clk);
    e_n = 1'b0; w_n = 1'b0; hsb_n = 1'b0; addr = 8'd20; din = ~sram_m[20];
    @(negedge clk);
    w_n = 1'b1;
    @(negedge clk);
    idle(); hsb_n = 1'b1;
    do_read(8'd20, "R5 hsb low write ignored");

    // R8: store ignored while recall pending; R7 recall restores nv
    do_write(8'd40, ~nv_m[40], 1'b1);
    do_write(8'd41, ~nv_m[41], 1'b1);
    @(negedge clk);
    sup_low = 1'b1; sup_ok = 1'b0;
    @(negedge clk);
    sto_req = 1'b1;
    @(negedge clk);
    sto_req = 1'b0;
    chk(busy === 1'b0, "R8 store ignored pending recall", int'(busy), 0);
    @(negedge clk);
    chk(busy === 1'b0, "R8 store ignored pending recall", int'(busy), 0);
    sup_low = 1'b0; sup_ok = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R7 recall start", int'(busy), 1);
    // R9: read during busy blocked
    e_n = 1'b0; g_n = 1'b0; w_n = 1'b1; hsb_n = 1'b1; addr = 8'd5;
    @(negedge clk);
    chk(oe === 1'b0, "R9 read blocked", int'(oe), 0);
    idle();
    // R9: write during busy discarded; R8 store pulse ignored while busy
    do_write(8'd50, ~nv_m[50], 1'b0);
    @(negedge clk);
    sto_req = 1'b1;
    @(negedge clk);
    sto_req = 1'b0;
    count_busy(n);
    chk(n == RCL - 6, "R8 busy unaffected by store pulse", n, RCL - 6);
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, "R8 no store after busy", int'(busy), 0);
    for (int a = 0; a < DEP; a++) sram_m[a] = nv_m[a];
    do_read(8'd40, "R7 recall restores");
    do_read(8'd41, "R7 recall restores");
    do_read(8'd50, "R9 busy write discarded");
    for (int a = 0; a < 6; a++) do_read(AW'($urandom), "R7 recall restores");

    // R10: write overlapping recall end
    idle();
    supply_dip();
    n = 0;
    while (busy === 1'b1 && n < 5000) begin
      n++;
      if (n == RCL - 3) begin
        e_n = 1'b0; w_n = 1'b0; hsb_n = 1'b1; addr = 8'd77; din = ~nv_m[77];
      end
      @(negedge clk);
    end
    chk(n == RCL, "R7 recall length", n, RCL);
    @(negedge clk);
    chk(corrupt === 1'b1, "R10 corrupt set", int'(corrupt), 1);
    w_n = 1'b1;
    @(negedge clk);
    e_n = 1'b1;
    for (int a = 0; a < DEP; a++) sram_m[a] = nv_m[a];
    sram_m[77] = ~nv_m[77];
    do_read(8'd77, "R10 write still commits");
    idle();
    repeat (3) @(negedge clk);
    chk(corrupt === 1'b1, "R10 corrupt sticky", int'(corrupt), 1);
    supply_dip();
    chk(corrupt === 1'b0, "R10 corrupt cleared at recall start", int'(corrupt), 0);
    count_busy(n);
    for (int a = 0; a < DEP; a++) sram_m[a] = nv_m[a];
    do_read(8'd77, "R7 second recall");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule